// File: doc/BRIEF.md
# Per-Line Sharing Miss Classifier

This block sits next to one private cache line. It watches every local access to the line. It separates coherence misses from other misses. For each coherence miss it decides whether the miss came from true sharing or from false sharing. A coherence miss is one where the tag still matches but the line has lost its permission. The verdict is not fixed when the miss happens. It stays open for as long as the line remains resident after the miss, and any access in that time that touches a word exchanged with another core turns the verdict into true sharing.

When the miss happens, a global tracker supplies two vectors with one bit per word: the words other cores wrote and the words other cores read since this core last held the line. At the same moment the block latches the PC of the missing access. When the line leaves the cache (invalidation, downgrade or replacement), the block does three things. It hands its local read and write vectors back to the tracker. It emits a record holding the miss PC and the false-sharing verdict, but only if a coherence miss was seen. It then clears its state for the next fill. The record leaves through a valid/ready port, and a pending record stalls the acknowledge of the next eviction.

Top module: `share_miss_classifier`

## Requirements
- R1: For an access, `kind_o` reports 2'b01 (non-coherence miss) when the tag does not match. It reports 2'b10 (coherence miss) when the tag matches and the line is invalid, or when the access is a write and the line is read-only. Otherwise it reports 2'b00. With no access, it reports 2'b00.
- R2: A coherence miss sets the miss flag and latches that access's PC as the miss PC. It also captures the others-wrote and others-read vectors present on that cycle. Vectors offered on other cycles are ignored.
- R3: After a coherence miss, a read of word K marks the miss as true sharing if others-wrote[K] is 1.
- R4: After a coherence miss, a write of word K marks the miss as true sharing if others-wrote[K] or others-read[K] is 1.
- R5: The access that causes the miss is itself judged by the R3/R4 rule, using the vectors captured on that same cycle. Once true sharing is marked, it stays marked until the line is evicted.
- R6: Every accepted local write of word K sets local-write bit K and clears local-read bit K. Every accepted local read sets local-read bit K.
- R7: An eviction request is acknowledged in its first cycle if no record is pending. In that cycle `exp_valid_o` is high and `exp_wr_o`/`exp_rd_o` carry the local vectors.
- R8: On an acknowledged eviction a record is produced only if a coherence miss was seen since the last eviction. Its `rec_false_o` is 1 when no true sharing was marked.
- R9: After an acknowledged eviction the local vectors, the miss flag and the verdict are cleared.
- R10: A record holds valid with stable fields until `rec_ready_i` is sampled high. While it is held, eviction acknowledges are withheld.
- R11: An access presented while an eviction request is high is ignored. It reports 2'b00 and changes no local vector.
- R12: After reset no record is pending and all local vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Local access this cycle |
| acc_write_i | input | 1 | Access is a write |
| acc_word_i | input | IDX_W | Word index within the line |
| acc_pc_i | input | PC_W | PC of the access |
| tag_match_i | input | 1 | Lookup found a matching tag |
| line_valid_i | input | 1 | Matching line holds a valid state |
| line_ro_i | input | 1 | Matching line is read-only |
| oth_wr_i | input | WORDS | Words written by other cores, used at miss time |
| oth_rd_i | input | WORDS | Words read by other cores, used at miss time |
| kind_o | output | 2 | Lookup class of the current access |
| evict_valid_i | input | 1 | Invalidation, downgrade or replacement request |
| evict_ack_o | output | 1 | Eviction accepted this cycle |
| exp_valid_o | output | 1 | Local vectors offered to the global tracker |
| exp_wr_o | output | WORDS | Local write vector |
| exp_rd_o | output | WORDS | Local read vector |
| rec_valid_o | output | 1 | Classification record pending |
| rec_ready_i | input | 1 | Consumer takes the record |
| rec_pc_o | output | PC_W | PC of the coherence miss |
| rec_false_o | output | 1 | 1 = false sharing, 0 = true sharing |

## Verification
Assertions check four rules on every cycle. The miss PC is latched on a coherence miss. A true-sharing verdict never reverts before eviction. A local write sets its write bit and clears its read bit. A pending record stays stable, and the line state is cleared after an eviction and left unchanged by an access that arrives during a stalled eviction. Only the bench scenarios can show that the verdict is correct. They sweep the access types at the missing word and at a later word against every others-wrote and others-read combination. They also cover the lookup classes and the exported vectors, the stall and drain order around a pending record, and the absence of a record after a plain miss.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [1:0] {
    KIND_HIT   = 2'b00,
    KIND_PLAIN = 2'b01,
    KIND_COH   = 2'b10
  } acc_kind_e;

  // write is true-sharing if any remote touch; read only if remote write
  function automatic logic is_true_share(logic wr, logic rem_wr, logic rem_rd);
    return wr ? (rem_wr | rem_rd) : rem_wr;
  endfunction
endpackage

// File: rtl/shm_lookup.sv
module shm_lookup
  import shm_pkg::*;
(
  input  logic      acc_i,
  input  logic      wr_i,
  input  logic      tag_hit_i,
  input  logic      valid_i,
  input  logic      ro_i,
  output acc_kind_e kind_o
);
  always_comb begin
    if (!acc_i)                          kind_o = KIND_HIT;
    else if (!tag_hit_i)                 kind_o = KIND_PLAIN;
    else if (!valid_i || (wr_i && ro_i)) kind_o = KIND_COH;
    else                                 kind_o = KIND_HIT;
  end
endmodule

// File: rtl/shm_word_vec.sv
module shm_word_vec #(
  parameter int WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             clr_i,
  output logic [WORDS-1:0] lw_o,
  output logic [WORDS-1:0] lr_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = upd_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lw_o[g] <= 1'b0;
        lr_o[g] <= 1'b0;
      end else if (clr_i) begin
        lw_o[g] <= 1'b0;
        lr_o[g] <= 1'b0;
      end else if (hit) begin
        if (wr_i) lw_o[g] <= 1'b1;
        lr_o[g] <= !wr_i;
      end
    end
  end

  p_write_marks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && wr_i && !clr_i |=> lw_o[$past(idx_i)] && !lr_o[$past(idx_i)]);
  p_read_marks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !wr_i && !clr_i |=> lr_o[$past(idx_i)]);
endmodule

// File: rtl/shm_verdict.sv
module shm_verdict
  import shm_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int IDX_W = 4,
  parameter int PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             coh_miss_i,
  input  logic             upd_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [WORDS-1:0] oth_wr_i,
  input  logic [WORDS-1:0] oth_rd_i,
  input  logic             clr_i,
  output logic             cm_o,
  output logic             fs_o,
  output logic [PC_W-1:0]  pc_o
);
  logic [WORDS-1:0] ow_q, or_q, ow_sel, or_sel;
  logic             true_now;

  // the missing access is judged against the vectors arriving with it
  assign ow_sel   = coh_miss_i ? oth_wr_i : ow_q;
  assign or_sel   = coh_miss_i ? oth_rd_i : or_q;
  assign true_now = is_true_share(wr_i, ow_sel[idx_i], or_sel[idx_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cm_o <= 1'b0;
      fs_o <= 1'b0;
      pc_o <= '0;
      ow_q <= '0;
      or_q <= '0;
    end else if (clr_i) begin
      cm_o <= 1'b0;
      fs_o <= 1'b0;
      ow_q <= '0;
      or_q <= '0;
    end else if (coh_miss_i) begin
      cm_o <= 1'b1;
      fs_o <= !true_now;
      pc_o <= pc_i;
      ow_q <= oth_wr_i;
      or_q <= oth_rd_i;
    end else if (upd_i && cm_o && true_now) begin
      fs_o <= 1'b0;
    end
  end

  p_miss_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coh_miss_i && !clr_i |=> cm_o && (pc_o == $past(pc_i)));
  p_true_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_o && !fs_o && !clr_i && !coh_miss_i |=> !fs_o);
endmodule

// File: rtl/shm_rec_port.sv
module shm_rec_port #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evict_i,
  input  logic            cm_i,
  input  logic            fs_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            ready_i,
  output logic            ack_o,
  output logic            valid_o,
  output logic [PC_W-1:0] pc_o,
  output logic            fs_o
);
  assign ack_o = evict_i && !valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
      fs_o    <= 1'b0;
    end else if (ack_o && cm_i) begin
      valid_o <= 1'b1;
      pc_o    <= pc_i;
      fs_o    <= fs_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  p_rec_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(pc_o) && $stable(fs_o));
  p_rec_needs_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(cm_i));
endmodule

// File: rtl/share_miss_classifier.sv
module share_miss_classifier
  import shm_pkg::*;
#(
  parameter  int LINE_BYTES = 64,
  parameter  int WORD_BYTES = 4,
  parameter  int PC_W       = 32,
  localparam int WORDS      = LINE_BYTES / WORD_BYTES,
  localparam int IDX_W      = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [IDX_W-1:0] acc_word_i,
  input  logic [PC_W-1:0]  acc_pc_i,
  input  logic             tag_match_i,
  input  logic             line_valid_i,
  input  logic             line_ro_i,
  input  logic [WORDS-1:0] oth_wr_i,
  input  logic [WORDS-1:0] oth_rd_i,
  output logic [1:0]       kind_o,
  input  logic             evict_valid_i,
  output logic             evict_ack_o,
  output logic             exp_valid_o,
  output logic [WORDS-1:0] exp_wr_o,
  output logic [WORDS-1:0] exp_rd_o,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic [PC_W-1:0]  rec_pc_o,
  output logic             rec_false_o
);
  logic             acc_eff, coh_miss, cm, fs;
  logic [PC_W-1:0]  miss_pc;
  logic [WORDS-1:0] lw, lr;
  acc_kind_e        kind;

  // eviction owns the line; accesses in that window are dropped
  assign acc_eff  = acc_valid_i && !evict_valid_i;
  assign coh_miss = (kind == KIND_COH);
  assign kind_o   = kind;

  shm_lookup u_lookup (
    .acc_i     (acc_eff),
    .wr_i      (acc_write_i),
    .tag_hit_i (tag_match_i),
    .valid_i   (line_valid_i),
    .ro_i      (line_ro_i),
    .kind_o    (kind)
  );

  shm_word_vec #(.WORDS(WORDS), .IDX_W(IDX_W)) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (acc_eff),
    .wr_i   (acc_write_i),
    .idx_i  (acc_word_i),
    .clr_i  (evict_ack_o),
    .lw_o   (lw),
    .lr_o   (lr)
  );

  shm_verdict #(.WORDS(WORDS), .IDX_W(IDX_W), .PC_W(PC_W)) u_verdict (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .coh_miss_i (coh_miss),
    .upd_i      (acc_eff),
    .wr_i       (acc_write_i),
    .idx_i      (acc_word_i),
    .pc_i       (acc_pc_i),
    .oth_wr_i   (oth_wr_i),
    .oth_rd_i   (oth_rd_i),
    .clr_i      (evict_ack_o),
    .cm_o       (cm),
    .fs_o       (fs),
    .pc_o       (miss_pc)
  );

  shm_rec_port #(.PC_W(PC_W)) u_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evict_i (evict_valid_i),
    .cm_i    (cm),
    .fs_i    (fs),
    .pc_i    (miss_pc),
    .ready_i (rec_ready_i),
    .ack_o   (evict_ack_o),
    .valid_o (rec_valid_o),
    .pc_o    (rec_pc_o),
    .fs_o    (rec_false_o)
  );

  assign exp_valid_o = evict_ack_o;
  assign exp_wr_o    = lw;
  assign exp_rd_o    = lr;

  p_clear_after_evict_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_ack_o |=> (lw == '0) && (lr == '0) && !cm);
  p_stalled_access_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && evict_valid_i && !evict_ack_o |=> $stable(lw) && $stable(lr));
endmodule

// File: tb/sim_share_miss_classifier.sv
`timescale 1ns/1ps
module sim_share_miss_classifier;
  localparam int W = 16;
  logic clk = 0, rst_ni = 0;
  logic acc_valid = 0, acc_write = 0, tag_match = 0, line_valid = 0, line_ro = 0;
  logic [3:0] acc_word = 0;
  logic [31:0] acc_pc = 0;
  logic [W-1:0] oth_wr = 0, oth_rd = 0;
  logic [1:0] kind;
  logic evict_valid = 0, evict_ack, exp_valid, rec_valid, rec_ready = 0, rec_false;
  logic [W-1:0] exp_wr, exp_rd;
  logic [31:0] rec_pc;
  int checks = 0, failures = 0;
  logic [W-1:0] ew = 0, er = 0;

  always #2.5 clk = ~clk;

  share_miss_classifier u0 (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_word_i(acc_word), .acc_pc_i(acc_pc), .tag_match_i(tag_match),
    .line_valid_i(line_valid), .line_ro_i(line_ro), .oth_wr_i(oth_wr), .oth_rd_i(oth_rd),
    .kind_o(kind), .evict_valid_i(evict_valid), .evict_ack_o(evict_ack),
    .exp_valid_o(exp_valid), .exp_wr_o(exp_wr), .exp_rd_o(exp_rd),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready), .rec_pc_o(rec_pc), .rec_false_o(rec_false)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int idx, input logic [31:0] pc, input bit tm,
                        input bit v, input bit ro, input logic [W-1:0] ow, input logic [W-1:0] orr,
                        input logic [1:0] exp_kind);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_word = 4'(idx); acc_pc = pc;
    tag_match = tm; line_valid = v; line_ro = ro; oth_wr = ow; oth_rd = orr;
    #1 chk(kind == exp_kind, "R1 kind", 64'(kind), 64'(exp_kind));
    @(posedge clk);
    #1 acc_valid = 0; oth_wr = 0; oth_rd = 0;
    if (wr) begin ew[idx] = 1; er[idx] = 0; end else er[idx] = 1;
  endtask

  task automatic evict(input bit exp_rec, input bit chk_fields, input logic [31:0] epc, input bit efs);
    @(negedge clk);
    evict_valid = 1;
    #1 chk(evict_ack && exp_valid, "R7 ack", 64'({evict_ack, exp_valid}), 64'(2'b11));
    chk(exp_wr == ew, "R6 export write vector", 64'(exp_wr), 64'(ew));
    chk(exp_rd == er, "R6 export read vector", 64'(exp_rd), 64'(er));
    @(posedge clk);
    #1 evict_valid = 0; ew = 0; er = 0;
    chk(rec_valid == exp_rec, "R8 record presence", 64'(rec_valid), 64'(exp_rec));
    if (exp_rec && chk_fields) begin
      chk(rec_pc == epc, "R2 miss pc", 64'(rec_pc), 64'(epc));
      chk(rec_false == efs, "R3 R4 R5 verdict", 64'(rec_false), 64'(efs));
    end
    if (exp_rec) begin
      @(negedge clk); rec_ready = 1;
      @(posedge clk); #1 rec_ready = 0;
      chk(!rec_valid, "R10 drain", 64'(rec_valid), 64'(0));
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R12 reset state
    chk(!rec_valid, "R12 no record after reset", 64'(rec_valid), 64'(0));
    chk(kind == 2'b00, "R1 idle kind", 64'(kind), 64'(0));
    evict(0, 0, 0, 0);

    // R1 sweep of lookup inputs
    for (int c = 0; c < 16; c++) begin
      logic [1:0] ek;
      if (!c[0]) ek = 2'b01;
      else if (!c[1] || (c[3] && c[2])) ek = 2'b10;
      else ek = 2'b00;
      access(c[3], c, 32'h40 + 32'(c), c[0], c[1], c[2], 0, 0, ek);
    end
    evict(1, 0, 0, 0);

    // R2-R6 sweep: missing access and a later access against all remote combos
    for (int i = 0; i < 64; i++) begin
      bit mt, st, t1, t2, use_ro;
      logic [1:0] ot, s2;
      int k, j;
      logic [W-1:0] ow, orr;
      mt = i[5]; ot = 2'(i >> 3); st = i[2]; s2 = 2'(i);
      k = i % 16; j = (k + 5) % 16;
      ow = 0; orr = 0;
      ow[k] = ot[1]; orr[k] = ot[0]; ow[j] = s2[1]; orr[j] = s2[0];
      t1 = mt ? (ot != 0) : ot[1];
      t2 = st ? (s2 != 0) : s2[1];
      use_ro = mt && k[0];
      access(mt, k, 32'h1000 + 32'(i * 4), 1, use_ro, use_ro, ow, orr, 2'b10);
      // vectors offered on a hit must be ignored (R2)
      access(st, j, 32'hdead, 1, 1, 0, ~ow, ~orr, 2'b00);
      evict(1, 1, 32'h1000 + 32'(i * 4), !(t1 || t2));
    end

    // R5 stickiness: true on second access, clean third access keeps it true
    begin
      logic [W-1:0] ow;
      ow = 0; ow[7] = 1;
      access(0, 2, 32'h2222, 1, 0, 0, ow, 0, 2'b10);
      access(0, 7, 32'h1, 1, 1, 0, 0, 0, 2'b00);
      access(1, 9, 32'h2, 1, 1, 0, 0, 0, 2'b00);
      evict(1, 1, 32'h2222, 0);
    end

    // R8 plain miss gives no record, vectors still exported
    access(0, 2, 32'h3000, 0, 0, 0, '1, '1, 2'b01);
    access(1, 4, 32'h3004, 1, 1, 0, '1, '1, 2'b00);
    evict(0, 0, 0, 0);
    // R9 second eviction sees cleared state
    evict(0, 0, 0, 0);

    // R10 / R11 stall with pending record
    access(0, 0, 32'h4444, 1, 0, 0, 0, 0, 2'b10);
    @(negedge clk); evict_valid = 1;
    @(posedge clk); #1 evict_valid = 0; ew = 0; er = 0;
    chk(rec_valid, "R10 record pending", 64'(rec_valid), 64'(1));
    @(negedge clk);
    evict_valid = 1; acc_valid = 1; acc_write = 1; acc_word = 3;
    tag_match = 1; line_valid = 1; line_ro = 0;
    #1 chk(!evict_ack, "R10 ack stalled", 64'(evict_ack), 64'(0));
    chk(kind == 2'b00, "R11 access ignored kind", 64'(kind), 64'(0));
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); #1;
      chk(rec_valid && rec_pc == 32'h4444 && rec_false == 1, "R10 record held",
          64'({rec_valid, rec_false, rec_pc}), 64'({2'b11, 32'h4444}));
      chk(!evict_ack, "R10 ack still stalled", 64'(evict_ack), 64'(0));
    end
    acc_valid = 0;
    @(negedge clk); rec_ready = 1;
    @(posedge clk); #1 rec_ready = 0;
    chk(!rec_valid, "R10 record taken", 64'(rec_valid), 64'(1'b0));
    @(negedge clk);
    #1 chk(evict_ack, "R10 ack released", 64'(evict_ack), 64'(1));
    chk(exp_wr == 0 && exp_rd == 0, "R11 ignored access left no trace",
        64'({exp_wr, exp_rd}), 64'(0));
    @(posedge clk); #1 evict_valid = 0;
    chk(!rec_valid, "R9 no record after cleared line", 64'(rec_valid), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule